// File: doc/BRIEF.md
# DMA Transfer Command Fragmenter

This block turns one two-dimensional transfer request into a stream of bus commands, each an address plus a byte length. A request names a start address, the byte count of one array, the number of arrays, a signed stride between array starts, and whether the address increments or stays fixed. A burst size set at build time is the upper bound on any command. Commands leave under a valid/ready handshake, and a one-cycle done pulse closes the request. A read side and a write side each use their own instance.

Inside a run of contiguous bytes the first command is trimmed so that every later one starts on a burst boundary. Every command is as long as the smaller of the distance to the next boundary and the bytes left in the run. When the arrays pack back to back, with a power-of-two array size no larger than the burst, a stride equal to the array size, no more than 1023 arrays and incrementing addresses, the whole request is fragmented as one contiguous run. In any other case each array is its own run.

Top module: `dmaFragmenter`

## Requirements
- R1: Every command offered on the output has a length between 1 and DBS bytes inclusive.
- R2: In increment mode no command crosses a DBS-aligned boundary, so every command after the first of a run starts on a multiple of DBS.
- R3: Each command length equals the smaller of (DBS minus the sizing address modulo DBS) and the bytes still left in the current run.
- R4: Without merging, array k (counting from 0) starts at the request address plus k times the stride, the stride being a two's complement value, and the arrays are issued in increasing k.
- R5: When the array size is a power of two, is at most DBS, equals the stride, the array count is at most 1023 and the mode is increment, the request is one run of array size times array count bytes starting at the request address.
- R6: When any one of the five conditions of R5 fails, each array is fragmented as a separate run of array-size bytes.
- R7: In constant mode (reqHold = 1) every command of an array carries that array's start address, and lengths are sized as in increment mode from that start address. No merging takes place.
- R8: While cmdValid is high and cmdReady is low, cmdValid, cmdAddr and cmdLen keep their values on the next cycle.
- R9: reqReady is high only when the block is idle. A request is taken on a cycle where reqValid and reqReady are both high. reqValid has no effect while the block is busy.
- R10: done is high for exactly one cycle, the cycle right after the handshake of the last command, and the block is idle on the following cycle.
- R11: A request with an array size of 0 or an array count of 0 emits no command, and done is high in the cycle after the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request can be taken |
| reqAddr | input | ADDR_W | Start address of the first array |
| reqAcnt | input | ACNT_W | Bytes per array |
| reqBcnt | input | BCNT_W | Number of arrays |
| reqBidx | input | BIDX_W | Signed stride between array starts |
| reqHold | input | 1 | 1 = constant address mode, 0 = increment |
| cmdValid | output | 1 | Command present |
| cmdReady | input | 1 | Command taken by the bus side |
| cmdAddr | output | ADDR_W | Command address |
| cmdLen | output | $clog2(DBS)+1 | Command length in bytes |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The assertions check on every cycle the local rules: the length bound, the ban on boundary crossing in increment mode, stable commands under backpressure, quiet outputs while idle, and a done that is a single pulse following a handshake or a request acceptance. Whether lengths are maximal, whether array starts follow the stride, whether the merge decision is right and whether the command count is exact all depend on the whole request. Only the bench can show these, by comparing each command against a sequence it builds from the request, including the 1023 and 1024 array-count limits, the negative stride, the oversize array and the constant mode.

// File: rtl/dmaFragPkg.sv
package dmaFragPkg;

  // Strobes from the control FSM into the datapath, at most one per cycle
  typedef struct packed {
    logic load;     // capture a new request
    logic step;     // advance inside the current run
    logic nextArr;  // move to the next array start
  } fragStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } fragState_t;

endpackage

// File: rtl/dmaFragMerge.sv
module dmaFragMerge #(
  parameter int ACNT_W    = 16,
  parameter int BCNT_W    = 16,
  parameter int BIDX_W    = 16,
  parameter int DBS       = 32,
  parameter int MERGE_MAX = 1023
) (
  input  logic [ACNT_W-1:0] acnt,
  input  logic [BCNT_W-1:0] bcnt,
  input  logic [BIDX_W-1:0] bidx,
  input  logic              hold,
  output logic              mergeOk
);
  localparam int EXT_W = (ACNT_W > BIDX_W) ? ACNT_W : BIDX_W;

  logic fitsBurst, isPow2, strideMatch, countFits, incMode;

  always_comb begin
    fitsBurst   = acnt <= ACNT_W'(DBS);
    isPow2      = (acnt != '0) && ((acnt & (acnt - ACNT_W'(1))) == '0);
    strideMatch = !bidx[BIDX_W-1] && (EXT_W'(bidx) == EXT_W'(acnt));
    countFits   = bcnt <= BCNT_W'(MERGE_MAX);
    incMode     = !hold;
    mergeOk     = fitsBurst && isPow2 && strideMatch && countFits && incMode;
  end

endmodule

// File: rtl/dmaFragPath.sv
module dmaFragPath
  import dmaFragPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ACNT_W = 16,
  parameter int BCNT_W = 16,
  parameter int BIDX_W = 16,
  parameter int DBS    = 32,
  localparam int OFF_W = $clog2(DBS),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fragStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ACNT_W-1:0] reqAcnt,
  input  logic [BCNT_W-1:0] reqBcnt,
  input  logic [BIDX_W-1:0] reqBidx,
  input  logic              reqHold,
  input  logic              mergeOk,
  output logic              reqEmpty,
  output logic              lastCmd,
  output logic              lastArray,
  output logic              holdActive,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [LEN_W-1:0]  cmdLen
);
  localparam int REM_W = ACNT_W + BCNT_W;

  logic [ADDR_W-1:0] arrStart, ptr, nextStart, bidxExt;
  logic [REM_W-1:0]  rem, loadRem;
  logic [BCNT_W-1:0] arrLeft;
  logic [ACNT_W-1:0] acntQ;
  logic [BIDX_W-1:0] bidxQ;
  logic              holdQ;
  logic [LEN_W-1:0]  toBound;

  always_comb begin
    reqEmpty  = (reqAcnt == '0) || (reqBcnt == '0);
    toBound   = LEN_W'(DBS) - {1'b0, ptr[OFF_W-1:0]};
    lastCmd   = rem <= REM_W'(toBound);
    cmdLen    = lastCmd ? rem[LEN_W-1:0] : toBound;
    lastArray = arrLeft == BCNT_W'(1);
    bidxExt   = {{(ADDR_W-BIDX_W){bidxQ[BIDX_W-1]}}, bidxQ};
    nextStart = arrStart + bidxExt;
    cmdAddr   = holdQ ? arrStart : ptr;
    loadRem   = mergeOk ? (REM_W'(reqAcnt) * REM_W'(reqBcnt)) : REM_W'(reqAcnt);
    holdActive = holdQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrStart <= '0;
      ptr      <= '0;
      rem      <= '0;
      arrLeft  <= '0;
      acntQ    <= '0;
      bidxQ    <= '0;
      holdQ    <= 1'b0;
    end else if (strobe.load) begin
      arrStart <= reqAddr;
      ptr      <= reqAddr;
      rem      <= loadRem;
      arrLeft  <= mergeOk ? BCNT_W'(1) : reqBcnt;
      acntQ    <= reqAcnt;
      bidxQ    <= reqBidx;
      holdQ    <= reqHold;
    end else if (strobe.nextArr) begin
      arrStart <= nextStart;
      ptr      <= nextStart;
      rem      <= REM_W'(acntQ);
      arrLeft  <= arrLeft - BCNT_W'(1);
    end else if (strobe.step) begin
      ptr <= ptr + ADDR_W'(cmdLen);
      rem <= rem - REM_W'(cmdLen);
    end
  end

endmodule

// File: rtl/dmaFragCtrl.sv
module dmaFragCtrl
  import dmaFragPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqEmpty,
  input  logic        cmdReady,
  input  logic        lastCmd,
  input  logic        lastArray,
  output logic        reqReady,
  output logic        cmdValid,
  output logic        done,
  output fragStrobe_t strobe
);
  fragState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqEmpty) begin
            stateNext = ST_DONE;
          end else begin
            strobe.load = 1'b1;
            stateNext   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (cmdReady) begin
          if (!lastCmd)       strobe.step    = 1'b1;
          else if (lastArray) stateNext      = ST_DONE;
          else                strobe.nextArr = 1'b1;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = state == ST_IDLE;
  assign cmdValid = state == ST_RUN;
  assign done     = state == ST_DONE;

endmodule

// File: rtl/dmaFragmenter.sv
module dmaFragmenter
  import dmaFragPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ACNT_W = 16,
  parameter int BCNT_W = 16,
  parameter int BIDX_W = 16,
  parameter int DBS    = 32,
  localparam int LEN_W = $clog2(DBS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ACNT_W-1:0] reqAcnt,
  input  logic [BCNT_W-1:0] reqBcnt,
  input  logic [BIDX_W-1:0] reqBidx,
  input  logic              reqHold,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [LEN_W-1:0]  cmdLen,
  output logic              done
);
  fragStrobe_t strobe;
  logic mergeOk, reqEmpty, lastCmd, lastArray, holdActive;

  dmaFragMerge #(
    .ACNT_W(ACNT_W), .BCNT_W(BCNT_W), .BIDX_W(BIDX_W), .DBS(DBS), .MERGE_MAX(1023)
  ) uMerge (
    .acnt(reqAcnt), .bcnt(reqBcnt), .bidx(reqBidx), .hold(reqHold), .mergeOk(mergeOk)
  );

  dmaFragPath #(
    .ADDR_W(ADDR_W), .ACNT_W(ACNT_W), .BCNT_W(BCNT_W), .BIDX_W(BIDX_W), .DBS(DBS)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqAcnt(reqAcnt), .reqBcnt(reqBcnt), .reqBidx(reqBidx),
    .reqHold(reqHold), .mergeOk(mergeOk), .reqEmpty(reqEmpty), .lastCmd(lastCmd),
    .lastArray(lastArray), .holdActive(holdActive), .cmdAddr(cmdAddr), .cmdLen(cmdLen)
  );

  dmaFragCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEmpty(reqEmpty),
    .cmdReady(cmdReady), .lastCmd(lastCmd), .lastArray(lastArray),
    .reqReady(reqReady), .cmdValid(cmdValid), .done(done), .strobe(strobe)
  );

endmodule

// File: rtl/dmaFragChecker.sv
module dmaFragChecker #(
  parameter int ADDR_W = 32,
  parameter int DBS    = 32,
  localparam int OFF_W = $clog2(DBS),
  localparam int LEN_W = OFF_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [LEN_W-1:0]  cmdLen,
  input logic              done,
  input logic              holdActive
);
  // R1
  len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdLen != '0) && (cmdLen <= LEN_W'(DBS)));

  // R2
  no_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !holdActive) |->
      (({1'b0, {1'b0, cmdAddr[OFF_W-1:0]}} + {1'b0, cmdLen}) <= (LEN_W+1)'(DBS)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdLen)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!cmdValid && !done));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  // R10 R11
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(cmdValid && cmdReady) || $past(reqValid && reqReady)));

endmodule

bind dmaFragmenter dmaFragChecker #(.ADDR_W(ADDR_W), .DBS(DBS)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
  .done(done), .holdActive(holdActive)
);

// File: tb/tb_dmaFragmenter.sv
module tb_dmaFragmenter;
  localparam int DBS = 32;
  localparam int LEN_W = $clog2(DBS) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqAcnt = '0, reqBcnt = '0, reqBidx = '0;
  logic reqHold = 1'b0;
  logic cmdValid;
  logic cmdReady = 1'b0;
  logic [31:0] cmdAddr;
  logic [LEN_W-1:0] cmdLen;
  logic done;

  int nTests = 0;
  int nFail = 0;
  logic [31:0] expAddr[$];
  int expLen[$];

  always #4 clk = ~clk;

  dmaFragmenter #(.ADDR_W(32), .ACNT_W(16), .BCNT_W(16), .BIDX_W(16), .DBS(DBS)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqAcnt(reqAcnt), .reqBcnt(reqBcnt), .reqBidx(reqBidx),
    .reqHold(reqHold), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected command sequence, built from R3..R7 and R11
  task automatic buildExp(input logic [31:0] a, input int acnt, input int bcnt,
                          input int bidx, input bit hold);
    bit merged;
    int runs, runLen;
    expAddr.delete();
    expLen.delete();
    merged = acnt > 0 && acnt <= DBS && (acnt & (acnt - 1)) == 0 &&
             bidx == acnt && bcnt <= 1023 && !hold;
    if (acnt == 0 || bcnt == 0) return;
    runs   = merged ? 1 : bcnt;
    runLen = merged ? acnt * bcnt : acnt;
    for (int r = 0; r < runs; r++) begin
      logic [31:0] st, p;
      int rem;
      st  = a + 32'(r * bidx);
      p   = st;
      rem = runLen;
      while (rem > 0) begin
        int tb, l;
        tb = DBS - int'(p % DBS);
        l  = (rem < tb) ? rem : tb;
        expAddr.push_back(hold ? st : p);
        expLen.push_back(l);
        p   = p + 32'(l);
        rem = rem - l;
      end
    end
  endtask

  task automatic runReq(input logic [31:0] a, input int acnt, input int bcnt,
                        input int bidx, input bit hold, input int readyPct,
                        input string tag);
    int idx, n, cyc;
    bit gotDone, prevHs, stalled;
    logic [31:0] stAddr;
    logic [LEN_W-1:0] stLen;
    buildExp(a, acnt, bcnt, bidx, hold);
    n = expAddr.size();
    @(negedge clk);
    check(reqReady == 1'b1, "R9", "reqReady before request", longint'(reqReady), 1);
    reqAddr = a; reqAcnt = 16'(acnt); reqBcnt = 16'(bcnt);
    reqBidx = 16'(bidx); reqHold = hold; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    idx = 0; cyc = 0; gotDone = 0; prevHs = 1; stalled = 0;
    stAddr = '0; stLen = '0;
    while (!gotDone && cyc < 20000) begin
      reqValid = 1'b0;
      if (done) begin
        gotDone = 1;
        cmdReady = 1'b0;
        // R10, R11: done right after the last handshake (or the acceptance when empty)
        check(prevHs && idx == n, (n == 0) ? "R11" : "R10", "done timing / command count",
              idx, n);
      end else if (!cmdValid) begin
        check(1'b0, "R8", "cmdValid dropped while busy", 0, 1);
        prevHs = 0;
      end else begin
        bit rdy;
        if (stalled) begin
          check(cmdAddr == stAddr && cmdLen == stLen, "R8", "stalled command changed",
                longint'(cmdAddr), longint'(stAddr));
        end
        prevHs = 0;
        rdy = int'($urandom % 100) < readyPct;
        cmdReady = rdy;
        if (rdy) begin
          stalled = 0;
          check(int'(cmdLen) >= 1 && int'(cmdLen) <= DBS, "R1", "length bound",
                longint'(cmdLen), DBS);
          if (idx < n) begin
            check(cmdAddr == expAddr[idx], tag, $sformatf("R4 addr of cmd %0d", idx),
                  longint'(cmdAddr), longint'(expAddr[idx]));
            check(int'(cmdLen) == expLen[idx], tag, $sformatf("R3 len of cmd %0d", idx),
                  longint'(cmdLen), longint'(expLen[idx]));
          end else begin
            check(1'b0, tag, "extra command", idx, n);
          end
          idx++;
          prevHs = 1;
        end else begin
          stalled = 1; stAddr = cmdAddr; stLen = cmdLen;
          // R9: a request while busy must be ignored
          if ($urandom % 4 == 0) begin
            reqAddr = $urandom; reqAcnt = 16'($urandom % 50);
            reqBcnt = 16'($urandom % 5); reqBidx = 16'($urandom); reqValid = 1'b1;
          end
        end
      end
      @(negedge clk);
      cyc++;
    end
    if (!gotDone) check(1'b0, tag, "done never seen", 0, 1);
    check(done == 1'b0 && reqReady == 1'b1, "R10", "done single pulse then idle",
          longint'({done, reqReady}), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // reset state (R9)
    check(reqReady == 1'b1 && cmdValid == 1'b0 && done == 1'b0, "R9", "reset outputs",
          longint'({reqReady, cmdValid, done}), 4);
    rstN = 1'b1;
    // R5 merged, aligned and unaligned
    runReq(32'h1000, 4, 16, 4, 0, 100, "R5");
    runReq(32'h1005, 4, 16, 4, 0, 70, "R5 R2");
    runReq(32'h2000, 8, 1023, 8, 0, 90, "R5");
    // R6: each condition failing alone
    runReq(32'h2000, 8, 1024, 8, 0, 100, "R6");
    runReq(32'h0003, 3, 5, 3, 0, 80, "R6");
    runReq(32'h0010, 64, 3, 64, 0, 60, "R6 R3");
    runReq(32'h0400, 8, 4, 16, 0, 80, "R6");
    runReq(32'h0400, 8, 4, 8, 1, 80, "R6 R7");
    // R7 constant mode
    runReq(32'h3003, 70, 3, 100, 1, 50, "R7");
    // R4 negative stride
    runReq(32'h8000, 20, 4, -40, 0, 75, "R4");
    // R11 empty requests
    runReq(32'h5000, 0, 5, 0, 0, 100, "R11");
    runReq(32'h5000, 5, 0, 5, 0, 100, "R11");
    // heavy backpressure (R8)
    runReq(32'h6011, 100, 2, 128, 0, 20, "R8 R6");
    // constrained random
    for (int t = 0; t < 100; t++) begin
      int acnt, bcnt, bidx, sel;
      bit hold;
      sel = int'($urandom % 4);
      case (sel)
        0: acnt = 1 << ($urandom % 6);
        1: acnt = 1 + int'($urandom % 100);
        2: acnt = 33 + int'($urandom % 170);
        default: acnt = int'($urandom % 9);
      endcase
      bcnt = ($urandom % 12 == 0) ? 0 : 1 + int'($urandom % 12);
      bidx = ($urandom % 2 == 0) ? acnt : int'($urandom % 601) - 300;
      hold = ($urandom % 100) < 15;
      runReq($urandom, acnt, bcnt, bidx, hold, 40 + int'($urandom % 61), "R3 R4 R6");
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule